// File: doc/BRIEF.md
# Glitch-Free Clock Bank Disable Controller

This block sits between a clock source and the pad drivers of five clock output banks. One bank of two outputs serves as the feedback bank. Four general banks have four outputs each. Each bank has an active-high disable input. A two-bit mode input, shared by all banks, decides what a disabled bank does.

In the high-impedance mode, a disabled bank drops its output enables at once, with no wait for a clock edge. In the park mode, the bank's clocks stop at a static level. Non-inverting outputs stop low and inverting outputs stop high, and the gate moves only while the affected output is already at its parked level. A third mode code hands the ungated clocks to the pads with every enable asserted, whatever the disable inputs are.

The clock arrives as two phases: a true phase and an inverted phase. Non-inverting outputs are gated from the true phase. Inverting outputs are gated from the inverted phase.

Top module: `cbd_ctrl`

## Requirements
- R1: After reset, and until a disable input is first raised, every output enable is high and every output follows its own clock phase (true outputs equal the true phase, inverting outputs equal the inverted phase).
- R2: A bank whose disable input is low is enabled and toggling, and disabling one bank leaves the outputs and enables of every other bank unchanged. Output layout: the feedback bank has bit 0 non-inverting and bit 1 inverting. General bank k drives bits [4k+3:4k], with bits 0 and 2 non-inverting and bits 1 and 3 inverting.
- R3: With mode code 2'b10 or 2'b11, a bank's output enables fall within the same time step as its disable input rises, with no clock edge needed.
- R4: With mode code 2'b00, a disabled bank's non-inverting outputs are held low. They change level only at a falling edge of the true phase.
- R5: When parked, inverting outputs are held high. They change level only at a rising edge of the inverted phase.
- R6: Once a bank's disable input rises, that bank reaches its parked levels within six true-phase clock cycles.
- R7: Outside entry into and exit from test mode, no output has a high or low pulse shorter than half a clock period.
- R8: When the disable input of a parked bank falls, its outputs resume toggling within six cycles, and the first pulse has full width.
- R9: When a bank leaves high impedance, its enables stay low until its clock gates are released on a safe edge. They then rise within six cycles of the disable input falling.
- R10: With mode code 2'b01, every output follows its raw clock phase and every enable is high, whatever the disable inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | True clock phase |
| clk_n_i | input | 1 | Inverted clock phase |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Disable mode: 00 park, 01 test, 10/11 high impedance |
| fb_dis_i | input | 1 | Feedback bank disable, active high |
| gen_dis_i | input | GEN_BANKS (4) | General bank disables, active high |
| fb_clk_o | output | FB_OUTS (2) | Feedback bank clocks |
| fb_oe_o | output | FB_OUTS (2) | Feedback bank output enables |
| gen_clk_o | output | GEN_BANKS*GEN_OUTS (16) | General bank clocks |
| gen_oe_o | output | GEN_BANKS*GEN_OUTS (16) | General bank output enables |

## Verification
The bench sweeps every bank under all three non-test mode codes. For each case it measures the cycle at which the bank parks and the cycle at which it resumes.

An edge monitor watches every output continuously. A gate register clocked on the wrong edge would show up as a runt pulse, or as an output that changes level away from its own phase edge. A missing hold on the enable would raise the enable while the gate is still closed, and this shows up in the check made right after release. A design that waited for an edge before entering high impedance would fail the same-step enable check.

Test mode is driven with every disable input high. A design that let the disables leak through test mode would show stopped clocks or low enables in that check.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef enum logic [1:0] {
    MODE_PARK = 2'b00,
    MODE_TEST = 2'b01,
    MODE_HIZ  = 2'b10,
    MODE_HIZ2 = 2'b11
  } cbd_mode_e;

  typedef struct packed {
    logic test;  // ungated pass-through, enables forced on
    logic hiz;   // disabled banks float instead of parking
  } cbd_ctl_t;

  function automatic cbd_ctl_t decode_mode(input logic [1:0] code);
    cbd_ctl_t c;
    c.test = (code == MODE_TEST);
    c.hiz  = code[1];
    return c;
  endfunction

endpackage

// File: rtl/cbd_sync.sv
module cbd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/cbd_bank.sv
module cbd_bank
  import cbd_pkg::*;
#(
  parameter int               NOUT        = 4,
  parameter logic [NOUT-1:0]  INV_MASK    = '0,
  parameter int               SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            clk_n_i,
  input  logic            rst_ni,
  input  logic            dis_i,
  input  cbd_ctl_t        ctl_i,
  output logic [NOUT-1:0] clk_o,
  output logic [NOUT-1:0] oe_o
);
  logic dis_s;
  logic gate_req;
  logic gate_t_q, gate_t_d;   // true-phase gate, moves while clk_i is low
  logic gate_i_q, gate_i_d;   // inverted-phase gate, moves while clk_n_i is high
  logic hiz_now;
  logic hz_q, hz_d;
  logic bank_oe;

  cbd_sync #(.STAGES(SYNC_STAGES)) u_dis_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dis_i),
    .q_o   (dis_s)
  );

  always_comb begin
    gate_req = dis_s & ~ctl_i.test;
    gate_t_d = gate_req;
    gate_i_d = gate_req;
    hiz_now  = dis_i & ctl_i.hiz & ~ctl_i.test;
    // hold the float until both gates have let go
    hz_d     = hiz_now | (hz_q & ctl_i.hiz & ~ctl_i.test & (gate_t_q | gate_i_q));
    bank_oe  = ctl_i.test | ~(hiz_now | hz_q);
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_t_q <= 1'b0;
    else         gate_t_q <= gate_t_d;
  end

  always_ff @(posedge clk_n_i or negedge rst_ni) begin
    if (!rst_ni) gate_i_q <= 1'b0;
    else         gate_i_q <= gate_i_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hz_q <= 1'b0;
    else         hz_q <= hz_d;
  end

  for (genvar j = 0; j < NOUT; j++) begin : g_out
    if (INV_MASK[j]) begin : g_inv
      assign clk_o[j] = ctl_i.test ? clk_n_i : (clk_n_i | gate_i_q);
    end else begin : g_true
      assign clk_o[j] = ctl_i.test ? clk_i : (clk_i & ~gate_t_q);
    end
    assign oe_o[j] = bank_oe;
  end
endmodule

// File: rtl/cbd_ctrl.sv
module cbd_ctrl
  import cbd_pkg::*;
#(
  parameter int                  GEN_BANKS    = 4,
  parameter int                  GEN_OUTS     = 4,
  parameter int                  FB_OUTS      = 2,
  parameter logic [FB_OUTS-1:0]  FB_INV_MASK  = 2'b10,
  parameter logic [GEN_OUTS-1:0] GEN_INV_MASK = 4'b1010,
  parameter int                  SYNC_STAGES  = 2
) (
  input  logic                          clk_i,
  input  logic                          clk_n_i,
  input  logic                          rst_ni,
  input  logic [1:0]                    mode_i,
  input  logic                          fb_dis_i,
  input  logic [GEN_BANKS-1:0]          gen_dis_i,
  output logic [FB_OUTS-1:0]            fb_clk_o,
  output logic [FB_OUTS-1:0]            fb_oe_o,
  output logic [GEN_BANKS*GEN_OUTS-1:0] gen_clk_o,
  output logic [GEN_BANKS*GEN_OUTS-1:0] gen_oe_o
);
  localparam int GEN_W = GEN_BANKS * GEN_OUTS;

  logic     rst_sync_n;
  cbd_ctl_t ctl;

  assign ctl = decode_mode(mode_i);

  cbd_sync #(.STAGES(2)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  cbd_bank #(
    .NOUT(FB_OUTS), .INV_MASK(FB_INV_MASK), .SYNC_STAGES(SYNC_STAGES)
  ) u_fb (
    .clk_i  (clk_i),
    .clk_n_i(clk_n_i),
    .rst_ni (rst_sync_n),
    .dis_i  (fb_dis_i),
    .ctl_i  (ctl),
    .clk_o  (fb_clk_o),
    .oe_o   (fb_oe_o)
  );

  for (genvar b = 0; b < GEN_BANKS; b++) begin : g_bank
    cbd_bank #(
      .NOUT(GEN_OUTS), .INV_MASK(GEN_INV_MASK), .SYNC_STAGES(SYNC_STAGES)
    ) u_gen (
      .clk_i  (clk_i),
      .clk_n_i(clk_n_i),
      .rst_ni (rst_sync_n),
      .dis_i  (gen_dis_i[b]),
      .ctl_i  (ctl),
      .clk_o  (gen_clk_o[b*GEN_OUTS +: GEN_OUTS]),
      .oe_o   (gen_oe_o[b*GEN_OUTS +: GEN_OUTS])
    );
  end

  if (GEN_W < 1) begin : g_bad
    initial $error("cbd_ctrl needs at least one general output");
  end
endmodule

// File: rtl/cbd_ctrl_chk.sv
module cbd_ctrl_chk #(
  parameter int                  GEN_BANKS    = 4,
  parameter int                  GEN_OUTS     = 4,
  parameter int                  FB_OUTS      = 2,
  parameter logic [FB_OUTS-1:0]  FB_INV_MASK  = 2'b10,
  parameter logic [GEN_OUTS-1:0] GEN_INV_MASK = 4'b1010
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [1:0]                    mode_i,
  input logic                          fb_dis_i,
  input logic [GEN_BANKS-1:0]          gen_dis_i,
  input logic [FB_OUTS-1:0]            fb_clk_o,
  input logic [FB_OUTS-1:0]            fb_oe_o,
  input logic [GEN_BANKS*GEN_OUTS-1:0] gen_clk_o,
  input logic [GEN_BANKS*GEN_OUTS-1:0] gen_oe_o
);
  localparam logic [2:0] PARK_LIMIT = 3'd6;

  logic       seen_q;
  logic [2:0] fb_cnt;
  logic [2:0] g_cnt [GEN_BANKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= seen_q | fb_dis_i | (|gen_dis_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             fb_cnt <= '0;
    else if (fb_dis_i && mode_i == 2'b00)    fb_cnt <= (fb_cnt == 3'd7) ? fb_cnt : fb_cnt + 3'd1;
    else                                     fb_cnt <= '0;
  end

  // R1: enables stay high until a disable is first seen
  p_reset_enabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !fb_dis_i && !(|gen_dis_i)) |-> (&fb_oe_o && &gen_oe_o));

  // R10: test mode forces every enable on
  p_test_oe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |-> (&fb_oe_o && &gen_oe_o));

  // R3: float is immediate
  p_fb_hiz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_dis_i && mode_i[1]) |-> (fb_oe_o == '0));

  // R6: parked levels reached within the limit (sampled in the high phase)
  p_fb_park_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (fb_cnt >= PARK_LIMIT) |-> (fb_clk_o == FB_INV_MASK));

  for (genvar b = 0; b < GEN_BANKS; b++) begin : g_chk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               g_cnt[b] <= '0;
      else if (gen_dis_i[b] && mode_i == 2'b00)  g_cnt[b] <= (g_cnt[b] == 3'd7) ? g_cnt[b] : g_cnt[b] + 3'd1;
      else                                       g_cnt[b] <= '0;
    end

    p_gen_hiz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gen_dis_i[b] && mode_i[1]) |-> (gen_oe_o[b*GEN_OUTS +: GEN_OUTS] == '0));

    p_gen_park_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (g_cnt[b] >= PARK_LIMIT) |-> (gen_clk_o[b*GEN_OUTS +: GEN_OUTS] == GEN_INV_MASK));

    // R9: enable never comes back while the bank is still asked to float
    p_gen_oe_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gen_oe_o[b*GEN_OUTS]) |-> (!gen_dis_i[b] || !mode_i[1]));
  end
endmodule

bind cbd_ctrl cbd_ctrl_chk #(
  .GEN_BANKS(GEN_BANKS), .GEN_OUTS(GEN_OUTS), .FB_OUTS(FB_OUTS),
  .FB_INV_MASK(FB_INV_MASK), .GEN_INV_MASK(GEN_INV_MASK)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .fb_dis_i (fb_dis_i),
  .gen_dis_i(gen_dis_i),
  .fb_clk_o (fb_clk_o),
  .fb_oe_o  (fb_oe_o),
  .gen_clk_o(gen_clk_o),
  .gen_oe_o (gen_oe_o)
);

// File: tb/sim_cbd_ctrl.sv
`timescale 1ns/1ps
module sim_cbd_ctrl;
  logic        clk = 1'b0;
  logic        clk_n;
  logic        rst_n;
  logic [1:0]  mode;
  logic [4:0]  dis;           // bit 0 feedback bank, bits 4:1 general banks
  logic [1:0]  fb_clk, fb_oe;
  logic [15:0] gen_clk, gen_oe;

  int n_tests = 0, n_fail = 0, runt_cnt = 0, pol_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign clk_n = ~clk;

  cbd_ctrl u0 (
    .clk_i(clk), .clk_n_i(clk_n), .rst_ni(rst_n), .mode_i(mode),
    .fb_dis_i(dis[0]), .gen_dis_i(dis[4:1]),
    .fb_clk_o(fb_clk), .fb_oe_o(fb_oe), .gen_clk_o(gen_clk), .gen_oe_o(gen_oe)
  );

  // edge monitor: R7 pulse width, R4/R5 edge polarity
  localparam logic [17:0] INVV = {{4{4'b1010}}, 2'b10};
  logic [17:0] all_clk;
  logic [17:0] prev;
  real         last_t [18];
  bit          mon_en = 0;
  assign all_clk = {gen_clk, fb_clk};

  task automatic mon_arm();
    prev = all_clk;
    for (int i = 0; i < 18; i++) last_t[i] = $realtime - 10.0;
    mon_en = 1;
  endtask

  always @(all_clk) begin
    if (mon_en) begin
      for (int i = 0; i < 18; i++) begin
        if (all_clk[i] !== prev[i]) begin
          if (all_clk[i] !== (INVV[i] ? clk_n : clk)) begin
            pol_cnt++;
            $display("monitor: output %0d moved off its own phase edge at %0t", i, $time);
          end
          if ($realtime - last_t[i] < 5.0) begin
            runt_cnt++;
            $display("monitor: short pulse on output %0d at %0t", i, $time);
          end
          last_t[i] = $realtime;
        end
      end
      prev = all_clk;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] bclk(int b);
    return (b == 0) ? {2'b00, fb_clk} : gen_clk[(b-1)*4 +: 4];
  endfunction
  function automatic logic bank_oe(int b);
    return (b == 0) ? &fb_oe : &gen_oe[(b-1)*4 +: 4];
  endfunction
  function automatic logic [3:0] park_pat(int b);
    return (b == 0) ? 4'b0010 : 4'b1010;
  endfunction
  function automatic logic [3:0] run_hi(int b);
    return (b == 0) ? 4'b0001 : 4'b0101;
  endfunction

  task automatic hi();  @(posedge clk); #2; endtask
  task automatic lo();  @(posedge clk); #7; endtask

  task automatic park_case(int b, logic [1:0] m);
    bit hz = m[1];
    int first;
    int o = (b + 1) % 5;
    mode = m;
    hi(); hi();
    dis[b] = 1'b1;
    #1;
    chk(bank_oe(b) == !hz, hz ? "R3 same-step float" : "R2 park keeps enable", bank_oe(b), !hz);
    first = 0;
    for (int n = 1; n <= 8; n++) begin
      hi();
      if (first == 0 && bclk(b) == park_pat(b)) first = n;
    end
    chk(first >= 1 && first <= 6, "R6 park latency", first, 6);
    hi();
    chk(bclk(b) == park_pat(b), "R4 R5 parked in high phase", bclk(b), park_pat(b));
    lo();
    chk(bclk(b) == park_pat(b), "R4 R5 parked in low phase", bclk(b), park_pat(b));
    chk(bank_oe(b) == !hz, hz ? "R3 float held" : "R2 enable held", bank_oe(b), !hz);
    hi();
    chk(bclk(o) == run_hi(o) && bank_oe(o), "R2 neighbour untouched", bclk(o), run_hi(o));
    hi();
    dis[b] = 1'b0;
    #1;
    chk(bank_oe(b) == !hz, hz ? "R9 enable waits for gate" : "R8 enable kept", bank_oe(b), !hz);
    first = 0;
    for (int n = 1; n <= 8; n++) begin
      hi();
      if (first == 0 && bclk(b) == run_hi(b) && bank_oe(b)) first = n;
    end
    chk(first >= 1 && first <= 6, hz ? "R9 release latency" : "R8 resume latency", first, 6);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode  = 2'b00;
    dis   = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) hi();
    mon_arm();

    // R1 reset state
    hi();
    chk(&fb_oe && &gen_oe, "R1 enables after reset", {fb_oe, gen_oe}, 18'h3ffff);
    chk(all_clk == ~INVV, "R1 outputs high phase", all_clk, ~INVV);
    lo();
    chk(all_clk == INVV, "R1 outputs low phase", all_clk, INVV);

    // sweep every bank under every non-test code
    for (int mi = 0; mi < 3; mi++) begin
      for (int b = 0; b < 5; b++) begin
        park_case(b, (mi == 0) ? 2'b00 : (mi == 1) ? 2'b10 : 2'b11);
      end
    end

    // R10 test mode with every disable high
    mon_en = 0;
    mode = 2'b01;
    dis  = '1;
    repeat (3) hi();
    chk(&fb_oe && &gen_oe, "R10 enables forced", {fb_oe, gen_oe}, 18'h3ffff);
    chk(all_clk == ~INVV, "R10 pass high phase", all_clk, ~INVV);
    lo();
    chk(all_clk == INVV, "R10 pass low phase", all_clk, INVV);

    // all banks parked together
    mode = 2'b00;
    repeat (8) hi();
    mon_arm();
    chk(all_clk == INVV, "R4 R5 all banks parked high phase", all_clk, INVV);
    lo();
    chk(all_clk == INVV, "R4 R5 all banks parked low phase", all_clk, INVV);
    hi();
    dis = '0;
    repeat (6) hi();
    chk(all_clk == ~INVV && &fb_oe && &gen_oe, "R8 all banks resumed", all_clk, ~INVV);
    repeat (4) hi();

    chk(runt_cnt == 0, "R7 no short pulses", runt_cnt, 0);
    chk(pol_cnt == 0, "R4 R5 edge polarity", pol_cnt, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule